// File: doc/BRIEF.md
# Parallel Display Bus Strobe Generator

This block drives the control strobes of an 8080-style parallel display bus: chip select, write enable, read enable and the command/data select line. The host offers one access at a time: a command write, a data write, or a read. The shape of each access comes from two packed timing words. One word holds the assert and release tick of every strobe. The other holds the access lengths, a minimum chip-select width and the read sample point. Timing is counted in bus ticks. A granularity bit stretches every tick to two clocks, and four polarity bits invert the individual pins.

Requests arrive on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while an access runs and while a read response is still waiting. Read data leaves on a second valid/ready channel. `rsp_valid` stays high, with `rsp_data` held, until the host raises `rsp_ready`. A waiting response therefore holds back every new request.

The timing and control words are copied when a request is taken. The host may rewrite them during an access without disturbing it.

Top module: `lcdbus_strobe_gen`

## Requirements
- R1: After reset, `busy`, `done` and `rsp_valid` are low and `req_ready` is high. CS, WE and RE sit at their inactive level, A0 sits at the data level, and `bus_doe` is low.
- R2: A request is taken on an edge where `req_valid` and `req_ready` are both high. `busy` rises in the next clock. `req_ready` is low while `busy` or `rsp_valid` is high. `done` is high for exactly the one clock after an access ends, and `busy` is low in that clock.
- R3: The on/off word holds six fields, with strobe s active during ticks t where on(s) <= t < off(s). The fields are CS on [3:0], CS off [9:4], WE on [13:10], WE off [19:14], RE on [23:20] and RE off [29:24]. CS is released at tick max(CS off, CS on + CS pulse width).
- R4: The cycle word holds four fields: write length [5:0], read length [11:6], minimum CS pulse width [17:12] and read access tick [27:22]. An access lasts L ticks, where L = max(length for its kind, CS release tick, 1).
- R5: With control bit 4 clear, one tick is one clock. With bit 4 set, one tick is two clocks, so `busy` lasts 2*L clocks instead of L.
- R6: The polarity bits in the control word are bit 16 for A0, bit 17 for RE, bit 18 for WE and bit 19 for CS. With a bit clear, CS, WE and RE are active low, and A0 is low for a command and high for data. With a bit set, that pin is inverted. Polarity is taken at acceptance, and the idle levels follow the last accepted setting.
- R7: `req_kind` selects the access: 0 is a command write, 1 is a data write, and 2 or 3 is a read. WE pulses only on writes and RE only on reads. During a write, `bus_doe` is high and `bus_dout` carries `req_wdata` for the whole access.
- R8: During a read, `bus_din` is sampled on the edge that closes the first clock of tick equal to the access tick. The sample appears on `rsp_data` with `rsp_valid` at the end of the access, and stays stable until `rsp_ready` is high.
- R9: A change to `cfg_onoff`, `cfg_cycle` or `cfg_ctrl` while an access runs has no effect on that access: its strobes and its length follow the words present at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_onoff | input | 32 | Strobe assert/release ticks |
| cfg_cycle | input | 32 | Access lengths, CS pulse width, read sample tick |
| cfg_ctrl | input | 32 | Granularity (bit 4) and polarity (bits 16 to 19) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_kind | input | 2 | 0 command write, 1 data write, 2 or 3 read |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | DW | Captured read data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock pulse after an access ends |
| bus_cs_o | output | 1 | Chip select pin |
| bus_we_o | output | 1 | Write enable pin |
| bus_re_o | output | 1 | Read enable pin |
| bus_a0_o | output | 1 | Command/data select pin |
| bus_dout | output | DW | Bus write data |
| bus_doe | output | 1 | Bus data output enable |
| bus_din | input | DW | Bus read data |

## Verification
The bench builds the block with its defaults: DW=16, 4-bit on fields and 6-bit off fields. With these widths the fields sit at the bit positions the requirements name, and both the all-ones on value (15) and off value (63) can be programmed. The widened tick counter then lets a CS on value plus a pulse width stretch an access to 78 ticks, and the bench drives that case at both granularity settings. A changing `bus_din` pattern shows which exact clock the read sample is taken on.

// File: rtl/lcdbus_pkg.sv
package lcdbus_pkg;
  localparam int GRAN_BIT   = 4;
  localparam int POL_A0_BIT = 16;
  localparam int POL_RE_BIT = 17;
  localparam int POL_WE_BIT = 18;
  localparam int POL_CS_BIT = 19;
  localparam int CFG_W      = 32;

  localparam int STB_CS  = 0;
  localparam int STB_WE  = 1;
  localparam int STB_RE  = 2;
  localparam int NUM_STB = 3;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_READ  = 2'd2,
    KIND_READB = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/lcdbus_tick_gen.sv
module lcdbus_tick_gen #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             gran,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic [CNT_W-1:0] tick,
  output logic             first,
  output logic             fin
);
  logic             sub;
  logic [CNT_W-1:0] last_tick;

  assign last_tick = len - CNT_W'(1);
  assign first     = !sub;
  assign fin       = busy && (!gran || sub) && (tick == last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tick <= '0;
      sub  <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      tick <= '0;
      sub  <= 1'b0;
    end else if (busy) begin
      if (gran && !sub) begin
        sub <= 1'b1;
      end else begin
        sub <= 1'b0;
        if (tick == last_tick) busy <= 1'b0;
        else                   tick <= tick + CNT_W'(1);
      end
    end
  end

  // R4: the tick counter never runs past the access length
  assert_tick_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tick < len));
endmodule

// File: rtl/lcdbus_strobe_win.sv
module lcdbus_strobe_win #(
  parameter int CNT_W = 7
) (
  input  logic             en,
  input  logic [CNT_W-1:0] tick,
  input  logic [CNT_W-1:0] on_t,
  input  logic [CNT_W-1:0] off_t,
  input  logic             pol,
  output logic             pin
);
  logic active;
  assign active = en && (tick >= on_t) && (tick < off_t);
  assign pin    = pol ? active : !active;
endmodule

// File: rtl/lcdbus_rd_capture.sv
module lcdbus_rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic [DW-1:0] din,
  input  logic          finish,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (sample) rsp_data <= din;
      if (finish)                      rsp_valid <= 1'b1;
      else if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
    end
  end

  // R8: a waiting response keeps its value until it is taken
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/lcdbus_strobe_gen.sv
module lcdbus_strobe_gen
  import lcdbus_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ON_W  = 4,
  parameter int OFF_W = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg_onoff,
  input  logic [31:0]   cfg_cycle,
  input  logic [31:0]   cfg_ctrl,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          done,
  output logic          bus_cs_o,
  output logic          bus_we_o,
  output logic          bus_re_o,
  output logic          bus_a0_o,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din
);
  localparam int CNT_W      = OFF_W + 1;
  localparam int CSON_LSB   = 0;
  localparam int CSOFF_LSB  = ON_W;
  localparam int WEON_LSB   = ON_W + OFF_W;
  localparam int WEOFF_LSB  = 2*ON_W + OFF_W;
  localparam int REON_LSB   = 2*ON_W + 2*OFF_W;
  localparam int REOFF_LSB  = 3*ON_W + 2*OFF_W;
  localparam int ONOFF_USED = 3*ON_W + 3*OFF_W;
  localparam int WCYC_LSB   = 0;
  localparam int RCYC_LSB   = OFF_W;
  localparam int CSPW_LSB   = 2*OFF_W;
  localparam int ACC_LSB    = 3*OFF_W + 4;
  localparam int CYCLE_USED = ACC_LSB + OFF_W;

  // fields of the incoming words, widened to the counter width
  logic [CNT_W-1:0] f_cson, f_csoff, f_weon, f_weoff, f_reon, f_reoff;
  logic [CNT_W-1:0] f_wcyc, f_rcyc, f_cspw, f_acc;
  logic [CNT_W-1:0] cs_rel_n, cyc_n, len_n;
  logic             rd_n, accept;

  assign f_cson  = CNT_W'(cfg_onoff[CSON_LSB  +: ON_W]);
  assign f_csoff = CNT_W'(cfg_onoff[CSOFF_LSB +: OFF_W]);
  assign f_weon  = CNT_W'(cfg_onoff[WEON_LSB  +: ON_W]);
  assign f_weoff = CNT_W'(cfg_onoff[WEOFF_LSB +: OFF_W]);
  assign f_reon  = CNT_W'(cfg_onoff[REON_LSB  +: ON_W]);
  assign f_reoff = CNT_W'(cfg_onoff[REOFF_LSB +: OFF_W]);
  assign f_wcyc  = CNT_W'(cfg_cycle[WCYC_LSB  +: OFF_W]);
  assign f_rcyc  = CNT_W'(cfg_cycle[RCYC_LSB  +: OFF_W]);
  assign f_cspw  = CNT_W'(cfg_cycle[CSPW_LSB  +: OFF_W]);
  assign f_acc   = CNT_W'(cfg_cycle[ACC_LSB   +: OFF_W]);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_onoff[CFG_W-1:ONOFF_USED], cfg_cycle[CFG_W-1:CYCLE_USED],
                             cfg_cycle[ACC_LSB-1:3*OFF_W], cfg_ctrl[CFG_W-1:POL_CS_BIT+1],
                             cfg_ctrl[POL_A0_BIT-1:GRAN_BIT+1], cfg_ctrl[GRAN_BIT-1:0]};

  assign rd_n = req_kind[1];

  always_comb begin
    cs_rel_n = (f_csoff > f_cson + f_cspw) ? f_csoff : (f_cson + f_cspw);
    cyc_n    = rd_n ? f_rcyc : f_wcyc;
    len_n    = (cyc_n > cs_rel_n) ? cyc_n : cs_rel_n;
    if (len_n == '0) len_n = CNT_W'(1);
  end

  // settings held for the running access
  logic             rd_q, cmd_q, gran_q;
  logic             pa0_q, pre_q, pwe_q, pcs_q;
  logic [DW-1:0]    wdata_q;
  logic [CNT_W-1:0] cson_q, csrel_q, weon_q, weoff_q, reon_q, reoff_q, acc_q, len_q;

  assign req_ready = !busy && !rsp_valid;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0; cmd_q <= 1'b0; gran_q <= 1'b0;
      pa0_q <= 1'b0; pre_q <= 1'b0; pwe_q <= 1'b0; pcs_q <= 1'b0;
      wdata_q <= '0;
      cson_q <= '0; csrel_q <= '0; weon_q <= '0; weoff_q <= '0;
      reon_q <= '0; reoff_q <= '0; acc_q <= '0; len_q <= CNT_W'(1);
    end else if (accept) begin
      rd_q    <= rd_n;
      cmd_q   <= (acc_kind_e'(req_kind) == KIND_CMD);
      gran_q  <= cfg_ctrl[GRAN_BIT];
      pa0_q   <= cfg_ctrl[POL_A0_BIT];
      pre_q   <= cfg_ctrl[POL_RE_BIT];
      pwe_q   <= cfg_ctrl[POL_WE_BIT];
      pcs_q   <= cfg_ctrl[POL_CS_BIT];
      wdata_q <= req_wdata;
      cson_q  <= f_cson;  csrel_q <= cs_rel_n;
      weon_q  <= f_weon;  weoff_q <= f_weoff;
      reon_q  <= f_reon;  reoff_q <= f_reoff;
      acc_q   <= f_acc;   len_q   <= len_n;
    end
  end

  logic [CNT_W-1:0] tick;
  logic             first, fin;

  lcdbus_tick_gen #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .start(accept), .gran(gran_q), .len(len_q),
    .busy(busy), .tick(tick), .first(first), .fin(fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= fin;
  end

  // one window comparator per strobe
  logic [CNT_W-1:0] w_on  [NUM_STB];
  logic [CNT_W-1:0] w_off [NUM_STB];
  logic             w_en  [NUM_STB];
  logic             w_pol [NUM_STB];
  logic             w_pin [NUM_STB];

  always_comb begin
    w_on[STB_CS] = cson_q; w_off[STB_CS] = csrel_q; w_en[STB_CS] = busy;          w_pol[STB_CS] = pcs_q;
    w_on[STB_WE] = weon_q; w_off[STB_WE] = weoff_q; w_en[STB_WE] = busy && !rd_q; w_pol[STB_WE] = pwe_q;
    w_on[STB_RE] = reon_q; w_off[STB_RE] = reoff_q; w_en[STB_RE] = busy && rd_q;  w_pol[STB_RE] = pre_q;
  end

  for (genvar s = 0; s < NUM_STB; s++) begin : g_win
    lcdbus_strobe_win #(.CNT_W(CNT_W)) u_win (
      .en(w_en[s]), .tick(tick), .on_t(w_on[s]), .off_t(w_off[s]),
      .pol(w_pol[s]), .pin(w_pin[s])
    );
  end

  assign bus_cs_o = w_pin[STB_CS];
  assign bus_we_o = w_pin[STB_WE];
  assign bus_re_o = w_pin[STB_RE];
  assign bus_a0_o = !(busy && cmd_q) ^ pa0_q;
  assign bus_dout = wdata_q;
  assign bus_doe  = busy && !rd_q;

  lcdbus_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .sample(busy && rd_q && first && (tick == acc_q)),
    .din(bus_din), .finish(fin && rd_q), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // R1: with no access running, the three strobes rest at their inactive level
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_cs_o == !pcs_q && bus_we_o == !pwe_q && bus_re_o == !pre_q));
  // R7: a read never pulses WE
  assert_we_quiet_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q) |-> (bus_we_o == !pwe_q));
  // R2: done lasts one clock
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: done only follows the end of an access
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);
endmodule

// File: tb/lcdbus_strobe_gen_tb.sv
module lcdbus_strobe_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_onoff = '0, cfg_cycle = '0, cfg_ctrl = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        busy, done;
  logic        bus_cs_o, bus_we_o, bus_re_o, bus_a0_o, bus_doe;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = 16'h0001;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5ns clk = ~clk;
  always @(posedge clk) bus_din <= bus_din + 16'h0103;

  lcdbus_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_onoff(cfg_onoff), .cfg_cycle(cfg_cycle), .cfg_ctrl(cfg_ctrl),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .done(done),
    .bus_cs_o(bus_cs_o), .bus_we_o(bus_we_o), .bus_re_o(bus_re_o), .bus_a0_o(bus_a0_o),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bench copy of the programmed settings
  int c_cson, c_csoff, c_weon, c_weoff, c_reon, c_reoff;
  int c_wcyc, c_rcyc, c_cspw, c_acc, c_g, c_pa0, c_pre, c_pwe, c_pcs;

  function automatic int clocks_for(input int rd);
    int rel, len;
    rel = imax(c_csoff, c_cson + c_cspw);
    len = imax(imax(rd ? c_rcyc : c_wcyc, rel), 1);
    return len * (c_g + 1);
  endfunction

  // R3 R4 R5 R6: pack the words at the field positions the requirements give
  task automatic set_cfg(input int cson, csoff, weon, weoff, reon, reoff,
                         input int wcyc, rcyc, cspw, acc,
                         input int g, pa0, pre, pwe, pcs);
    c_cson = cson; c_csoff = csoff; c_weon = weon; c_weoff = weoff; c_reon = reon; c_reoff = reoff;
    c_wcyc = wcyc; c_rcyc = rcyc; c_cspw = cspw; c_acc = acc;
    c_g = g; c_pa0 = pa0; c_pre = pre; c_pwe = pwe; c_pcs = pcs;
    cfg_onoff = 32'(cson) | (32'(csoff) << 4) | (32'(weon) << 10) | (32'(weoff) << 14)
              | (32'(reon) << 20) | (32'(reoff) << 24);
    cfg_cycle = 32'(wcyc) | (32'(rcyc) << 6) | (32'(cspw) << 12) | (32'(acc) << 22);
    cfg_ctrl  = (32'(g) << 4) | (32'(pa0) << 16) | (32'(pre) << 17) | (32'(pwe) << 18) | (32'(pcs) << 19);
  endtask

  // reference model, advanced on every rising edge
  int m_busy, m_c, m_tot, m_kind, m_wdata, m_rspv, m_rspd, m_done;
  int m_cson, m_csrel, m_weon, m_weoff, m_reon, m_reoff, m_acc, m_g, m_pa0, m_pre, m_pwe, m_pcs;
  int mt, mf, mrdy;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_c = 0; m_tot = 1; m_kind = 0; m_wdata = 0; m_rspv = 0; m_rspd = 0; m_done = 0;
      m_cson = 0; m_csrel = 0; m_weon = 0; m_weoff = 0; m_reon = 0; m_reoff = 0; m_acc = 0;
      m_g = 0; m_pa0 = 0; m_pre = 0; m_pwe = 0; m_pcs = 0;
    end else begin
      mrdy = (!m_busy && !m_rspv) ? 1 : 0;
      m_done = 0;
      if (m_rspv != 0 && rsp_ready) m_rspv = 0;
      if (m_busy != 0) begin
        mt = (m_g != 0) ? m_c / 2 : m_c;
        mf = (m_g != 0) ? ((m_c % 2) == 0) : 1;
        if (m_kind >= 2 && mt == m_acc && mf != 0) m_rspd = int'(bus_din);
        if (m_c == m_tot - 1) begin
          m_busy = 0; m_done = 1;
          if (m_kind >= 2) m_rspv = 1;
        end else m_c++;
      end else if (req_valid && mrdy != 0) begin
        m_kind = int'(req_kind); m_wdata = int'(req_wdata);
        m_cson = c_cson; m_csrel = imax(c_csoff, c_cson + c_cspw);
        m_weon = c_weon; m_weoff = c_weoff; m_reon = c_reon; m_reoff = c_reoff; m_acc = c_acc;
        m_g = c_g; m_pa0 = c_pa0; m_pre = c_pre; m_pwe = c_pwe; m_pcs = c_pcs;
        m_tot = clocks_for(m_kind >= 2);
        m_busy = 1; m_c = 0;
      end
    end
  end

  function automatic int pin(input int act, input int pol);
    return (pol != 0) ? act : ((act != 0) ? 0 : 1);
  endfunction

  // compare every output against the model, away from the active edge
  int et, ecs, ewe, ere;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      et  = (m_g != 0) ? m_c / 2 : m_c;
      ecs = (m_busy != 0) && et >= m_cson && et < m_csrel;
      ewe = (m_busy != 0) && m_kind < 2 && et >= m_weon && et < m_weoff;
      ere = (m_busy != 0) && m_kind >= 2 && et >= m_reon && et < m_reoff;
      chk("R2 busy", busy, m_busy);
      chk("R2 req_ready", req_ready, (!m_busy && !m_rspv));
      chk("R2 done", done, m_done);
      chk("R3 cs pin", bus_cs_o, pin(ecs, m_pcs));
      chk("R3 we pin", bus_we_o, pin(ewe, m_pwe));
      chk("R3 re pin", bus_re_o, pin(ere, m_pre));
      chk("R6 a0 pin", bus_a0_o, (((m_busy != 0) && m_kind == 0) ? 0 : 1) ^ m_pa0);
      chk("R7 doe", bus_doe, (m_busy != 0) && m_kind < 2);
      if (m_busy != 0 && m_kind < 2) chk("R7 dout", bus_dout, m_wdata);
      chk("R8 rsp_valid", rsp_valid, m_rspv);
      if (m_rspv != 0) chk("R8 rsp_data", rsp_data, m_rspd);
    end
  end

  // one access: offer, wait for acceptance, measure busy length
  task automatic run(input int kind, input int data, input string tag, input bit chg);
    int exp_clk, cnt;
    bit r;
    exp_clk = clocks_for(kind >= 2);
    req_kind = 2'(kind); req_wdata = 16'(data); req_valid = 1'b1;
    do begin
      @(negedge clk); r = req_ready;
      @(posedge clk);
    end while (!r);
    #1 req_valid = 1'b0;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (!busy) break;
      cnt++;
      // R9: rewrite every word mid-access
      if (chg && cnt == 2) set_cfg(0, 2, 0, 1, 0, 1, 2, 2, 0, 1, 0, 1, 1, 1, 1);
    end
    chk(tag, cnt, exp_clk);
    chk("R2 done at end", done, 1);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_cfg(1, 8, 2, 6, 2, 7, 9, 10, 3, 5, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 cs idle", bus_cs_o, 1);
    chk("R1 we idle", bus_we_o, 1);
    chk("R1 re idle", bus_re_o, 1);
    chk("R1 a0 idle", bus_a0_o, 1);
    chk("R1 doe", bus_doe, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;

    // R4 R7: command, data and read accesses at tick granularity 1
    run(0, 16'hA5C3, "R4 cmd length", 0);
    run(1, 16'h1234, "R4 data length", 0);
    run(2, 0, "R4 read length", 0);
    run(3, 0, "R7 read alias length", 0);
    // R5: doubled ticks
    set_cfg(1, 8, 2, 6, 2, 7, 9, 10, 3, 5, 1, 0, 0, 0, 0);
    run(0, 16'h00FF, "R5 cmd length gran", 0);
    run(2, 0, "R5 read length gran", 0);
    // R6: all polarities inverted
    set_cfg(0, 5, 1, 4, 1, 4, 6, 6, 0, 2, 0, 1, 1, 1, 1);
    run(0, 16'h0F0F, "R6 cmd inverted", 0);
    run(2, 0, "R6 read inverted", 0);
    // R3: pulse width stretches CS and the access
    set_cfg(2, 4, 2, 4, 2, 4, 5, 5, 6, 3, 0, 0, 0, 0, 0);
    run(1, 16'h7777, "R3 cs pulse stretch", 0);
    run(2, 0, "R3 cs pulse stretch read", 0);
    // R3 R4: widest fields, both granularities
    set_cfg(15, 63, 14, 40, 3, 50, 41, 60, 63, 49, 0, 0, 0, 0, 0);
    run(1, 16'hBEEF, "R4 wide write", 0);
    run(2, 0, "R4 wide read", 0);
    set_cfg(15, 63, 14, 40, 3, 50, 41, 60, 63, 49, 1, 0, 0, 0, 0);
    run(2, 0, "R5 wide read gran", 0);
    // R9: words rewritten during the access
    set_cfg(1, 8, 2, 6, 2, 7, 9, 10, 3, 5, 0, 0, 0, 0, 0);
    run(2, 0, "R9 length unchanged", 1);
    set_cfg(1, 8, 2, 6, 2, 7, 9, 10, 3, 5, 1, 0, 0, 0, 0);
    run(1, 16'h5A5A, "R9 length unchanged gran", 1);
    // R8 R2: response back-pressure blocks new requests
    set_cfg(1, 8, 2, 6, 2, 7, 9, 10, 3, 5, 0, 0, 0, 0, 0);
    @(posedge clk); #1 rsp_ready = 1'b0;
    run(2, 0, "R8 read length", 0);
    req_kind = 2'd1; req_wdata = 16'h4321; req_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 held off by response", req_ready, 0);
      chk("R8 response held", rsp_valid, 1);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    run(1, 16'h4321, "R2 write after response", 0);
    repeat (4) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule